// File: doc/BRIEF.md
# Write-Through Store Buffer with Drain Control

This block sits between a write-through data cache and main memory. Every processor store is posted into a small buffer, each slot keeping an address, a data word and a valid bit. The processor continues at once while a drain controller works through the pending stores in posting order. It presents each one to memory on a valid/ready handshake and frees the slot only once memory has taken the write.

The block also tells the processor when to stall. A store that finds every slot occupied is held, unless a slot is freed in that same cycle. A read miss is held until no store is pending anywhere, in the slots or on the memory port. Only then is the block fetch started, so the fetch can never overtake a store that is still queued. An empty flag reports that the buffer and the memory port are both idle.

Top module: `wt_post_buffer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `buf_empty` is 1, `mem_wr_valid` is 0 and `cpu_hold` is 0 with idle inputs; stores posted before a reset are never written to memory.
- R2: A store (`cpu_wr_req`=1) is accepted in the same cycle, with `cpu_hold`=0, whenever fewer than DEPTH (4) slots are occupied.
- R3: A store that arrives while all DEPTH slots are occupied and no memory handshake completes in that cycle raises `cpu_hold` and is not stored; the same store is accepted once repeated after a slot frees.
- R4: A store that arrives while all slots are occupied, in the same cycle as a completed memory handshake (`mem_wr_valid` and `mem_wr_ready` both 1), is accepted with `cpu_hold`=0.
- R5: Accepted stores are written to memory in the order they were accepted, each with its own address and data, exactly once.
- R6: Once `mem_wr_valid` is 1, it stays 1 with `mem_wr_addr` and `mem_wr_data` unchanged until a cycle in which `mem_wr_ready` is 1.
- R7: A slot stays occupied while its write is outstanding and is freed in the handshake cycle; after each handshake `mem_wr_valid` is 0 for one cycle before the next store is presented.
- R8: While `cpu_rd_miss` is 1 and the buffer is not empty, `cpu_hold` is 1 and `fetch_go` is 0; in a cycle where the buffer is empty, `fetch_go` is 1 and `cpu_hold` is 0.
- R9: `buf_empty` is 1 exactly when no slot is occupied and no memory write is outstanding; it depends on registered state only.
- R10: A store and a read miss in the same cycle with an empty buffer are both served: the store is accepted and `fetch_go` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_wr_req | input | 1 | Processor posts a store this cycle |
| cpu_wr_addr | input | AW (32) | Store address |
| cpu_wr_data | input | DW (32) | Store data |
| cpu_rd_miss | input | 1 | Processor has a read miss waiting for its block fetch |
| cpu_hold | output | 1 | Processor must stall this cycle |
| fetch_go | output | 1 | Block fetch for the read miss may start this cycle |
| mem_wr_valid | output | 1 | A buffered store is presented to memory |
| mem_wr_ready | input | 1 | Memory takes the presented store this cycle |
| mem_wr_addr | output | AW (32) | Address of the presented store |
| mem_wr_data | output | DW (32) | Data of the presented store |
| buf_empty | output | 1 | No slot occupied and no memory write outstanding |

## Verification
The assertions check on every cycle that the memory request stays stable until it is taken and that it drops only after a handshake. They also check that no store is ever written into a full buffer without a release in the same cycle, that occupancy moves by exactly the stores accepted less the slots freed, and that a granted fetch never coincides with pending memory traffic. Only the bench's scenarios can show end-to-end ordering and completeness: every accepted store reaching memory once, in order, with the right data, and a store held on a full buffer not being duplicated. The same holds for the exact cycle at which a held read miss is released after the last drain, and for the loss of stores posted before a reset.

// File: rtl/wtb_pkg.sv
package wtb_pkg;

    typedef enum logic {
        DRN_IDLE = 1'b0,
        DRN_BUSY = 1'b1
    } drain_state_e;

    function automatic int ptr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/wtb_slots.sv
module wtb_slots #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic [AW-1:0]        push_addr,
    input  logic [DW-1:0]        push_data,
    input  logic                 pop,
    output logic                 head_valid,
    output logic [AW-1:0]        head_addr,
    output logic [DW-1:0]        head_data,
    output logic [$clog2(DEPTH+1)-1:0] occ,
    output logic                 full
);
    localparam int PW = wtb_pkg::ptr_width(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0]         vld;
        logic [DEPTH-1:0][AW-1:0] adr;
        logic [DEPTH-1:0][DW-1:0] dat;
        logic [PW-1:0]            hd;
        logic [PW-1:0]            tl;
    } slot_st_t;

    slot_st_t s_d, s_q;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        // release first so that a store arriving in the freeing cycle
        // can reuse the same slot when the ring was full
        if (pop) begin
            s_d.vld[s_q.hd] = 1'b0;
            s_d.hd          = step_ptr(s_q.hd);
        end
        if (push) begin
            s_d.vld[s_q.tl] = 1'b1;
            s_d.adr[s_q.tl] = push_addr;
            s_d.dat[s_q.tl] = push_data;
            s_d.tl          = step_ptr(s_q.tl);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_valid = s_q.vld[s_q.hd];
    assign head_addr  = s_q.adr[s_q.hd];
    assign head_data  = s_q.dat[s_q.hd];
    assign occ        = CW'($countones(s_q.vld));
    assign full       = &s_q.vld;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));

    // R7
    pop_occupied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);

    // R5
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (int'(occ) == int'($past(occ)) + int'($past(push)) - int'($past(pop))));

endmodule

// File: rtl/wtb_drain.sv
module wtb_drain
    import wtb_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          head_valid,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    input  logic          mem_ready,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    output logic          pop,
    output logic          busy
);
    typedef struct packed {
        drain_state_e  st;
        logic [AW-1:0] adr;
        logic [DW-1:0] dat;
    } drn_st_t;

    drn_st_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        pop = 1'b0;
        unique case (r_q.st)
            DRN_IDLE: begin
                if (head_valid) begin
                    r_d.st  = DRN_BUSY;
                    r_d.adr = head_addr;
                    r_d.dat = head_data;
                end
            end
            DRN_BUSY: begin
                if (mem_ready) begin
                    pop    = 1'b1;
                    r_d.st = DRN_IDLE;
                end
            end
            default: r_d.st = DRN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: DRN_IDLE, adr: '0, dat: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st == DRN_BUSY);
    assign mem_valid = busy;
    assign mem_addr  = r_q.adr;
    assign mem_data  = r_q.dat;

    // R6
    mem_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R6
    drop_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_valid) |-> $past(mem_ready));

    // R7
    release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !mem_valid);

endmodule

// File: rtl/wtb_hold.sv
module wtb_hold (
    input  logic wr_req,
    input  logic rd_miss,
    input  logic full,
    input  logic pop,
    input  logic empty,
    output logic accept,
    output logic hold,
    output logic fetch_go
);
    logic wr_blocked;
    logic rd_blocked;

    always_comb begin
        accept     = wr_req && (!full || pop);
        wr_blocked = wr_req && !accept;
        rd_blocked = rd_miss && !empty;
        hold       = wr_blocked || rd_blocked;
        fetch_go   = rd_miss && empty;
    end

endmodule

// File: rtl/wt_post_buffer.sv
module wt_post_buffer #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr_req,
    input  logic [AW-1:0] cpu_wr_addr,
    input  logic [DW-1:0] cpu_wr_data,
    input  logic          cpu_rd_miss,
    output logic          cpu_hold,
    output logic          fetch_go,
    output logic          mem_wr_valid,
    input  logic          mem_wr_ready,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data,
    output logic          buf_empty
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          accept;
    logic          pop;
    logic          busy;
    logic          full;
    logic [CW-1:0] occ;
    logic          head_valid;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data;

    wtb_slots #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (accept),
        .push_addr  (cpu_wr_addr),
        .push_data  (cpu_wr_data),
        .pop        (pop),
        .head_valid (head_valid),
        .head_addr  (head_addr),
        .head_data  (head_data),
        .occ        (occ),
        .full       (full)
    );

    wtb_drain #(.AW(AW), .DW(DW)) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (head_valid),
        .head_addr  (head_addr),
        .head_data  (head_data),
        .mem_ready  (mem_wr_ready),
        .mem_valid  (mem_wr_valid),
        .mem_addr   (mem_wr_addr),
        .mem_data   (mem_wr_data),
        .pop        (pop),
        .busy       (busy)
    );

    // slots stay occupied while in flight, so the busy term only guards
    // against a launch register that outlives its slot
    assign buf_empty = (occ == '0) && !busy;

    wtb_hold u_hold (
        .wr_req   (cpu_wr_req),
        .rd_miss  (cpu_rd_miss),
        .full     (full),
        .pop      (pop),
        .empty    (buf_empty),
        .accept   (accept),
        .hold     (cpu_hold),
        .fetch_go (fetch_go)
    );

    // R8
    fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |=> !mem_wr_valid);

    // R8
    miss_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_miss && mem_wr_valid) |-> (cpu_hold && !fetch_go));

    // R4
    full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_req && full && mem_wr_valid && mem_wr_ready) |-> !cpu_hold);

    // R9
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty |-> (!mem_wr_valid && !full));

endmodule

// File: tb/test_wt_post_buffer.sv
module test_wt_post_buffer;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_wr_req = 1'b0;
    logic [AW-1:0] cpu_wr_addr = '0;
    logic [DW-1:0] cpu_wr_data = '0;
    logic          cpu_rd_miss = 1'b0;
    logic          cpu_hold;
    logic          fetch_go;
    logic          mem_wr_valid;
    logic          mem_wr_ready = 1'b0;
    logic [AW-1:0] mem_wr_addr;
    logic [DW-1:0] mem_wr_data;
    logic          buf_empty;

    int errors = 0;
    int checks = 0;
    int taken  = 0;
    int posted = 0;

    int exp_q [0:31];
    int wp = 0;
    int rp = 0;

    always #5 clk = ~clk;

    wt_post_buffer #(.DEPTH(4), .AW(AW), .DW(DW)) i_wt_post_buffer (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_wr_req   (cpu_wr_req),
        .cpu_wr_addr  (cpu_wr_addr),
        .cpu_wr_data  (cpu_wr_data),
        .cpu_rd_miss  (cpu_rd_miss),
        .cpu_hold     (cpu_hold),
        .fetch_go     (fetch_go),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_ready (mem_wr_ready),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .buf_empty    (buf_empty)
    );

    function automatic logic [AW-1:0] addr_of(input int k);
        return 32'h0000_1000 + AW'(k * 4);
    endfunction

    function automatic logic [DW-1:0] data_of(input int k);
        return 32'hA5A5_0000 | DW'(k);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
        end
    endtask

    // one cycle: drive at the falling edge, settle, check the memory side
    // against the posting order, record an accepted store
    task automatic cycle(input logic wr, input logic rd, input logic rdy, input int k);
        @(negedge clk);
        cpu_wr_req   = wr;
        cpu_rd_miss  = rd;
        mem_wr_ready = rdy;
        cpu_wr_addr  = addr_of(k);
        cpu_wr_data  = data_of(k);
        #1;
        if (mem_wr_valid) begin
            if (rp < wp) begin
                chk(mem_wr_addr, addr_of(exp_q[rp]), rdy ? "R5 mem_wr_addr order" : "R6 mem_wr_addr held");
                chk(mem_wr_data, data_of(exp_q[rp]), rdy ? "R5 mem_wr_data order" : "R6 mem_wr_data held");
            end else begin
                chk(32'(rp), 32'(wp - 1), "R5 memory write without a pending store");
            end
            if (rdy) begin
                rp++;
                taken++;
            end
        end
        if (wr && !cpu_hold) begin
            exp_q[wp] = k;
            wp++;
            posted++;
        end
    endtask

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic       rdy;
        logic [3:0] k;
        logic       hold;
        logic       fetch;
        logic       mv;
        logic       emp;
    } vec_t;

    localparam int NV = 23;
    // fields: wr rd rdy store hold fetch_go mem_wr_valid buf_empty
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b0,4'd0, 1'b0,1'b0,1'b0,1'b1},  // idle after reset
        '{1'b0,1'b1,1'b0,4'd0, 1'b0,1'b1,1'b0,1'b1},  // R8 miss on empty buffer
        '{1'b1,1'b0,1'b0,4'd1, 1'b0,1'b0,1'b0,1'b1},  // R2 first store
        '{1'b1,1'b0,1'b0,4'd2, 1'b0,1'b0,1'b0,1'b0},  // R9 not empty
        '{1'b1,1'b0,1'b0,4'd3, 1'b0,1'b0,1'b1,1'b0},  // drain launched
        '{1'b1,1'b0,1'b0,4'd4, 1'b0,1'b0,1'b1,1'b0},  // R2 fourth store
        '{1'b1,1'b0,1'b0,4'd5, 1'b1,1'b0,1'b1,1'b0},  // R3 full, held
        '{1'b1,1'b0,1'b1,4'd5, 1'b0,1'b0,1'b1,1'b0},  // R4 full, freed same cycle
        '{1'b0,1'b1,1'b0,4'd0, 1'b1,1'b0,1'b0,1'b0},  // R7 gap, R8 miss held
        '{1'b0,1'b1,1'b1,4'd0, 1'b1,1'b0,1'b1,1'b0},
        '{1'b0,1'b1,1'b1,4'd0, 1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b1,1'b1,4'd0, 1'b1,1'b0,1'b1,1'b0},
        '{1'b0,1'b1,1'b1,4'd0, 1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b1,1'b1,4'd0, 1'b1,1'b0,1'b1,1'b0},
        '{1'b0,1'b1,1'b1,4'd0, 1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b1,1'b1,4'd0, 1'b1,1'b0,1'b1,1'b0},  // R8 last store in flight
        '{1'b0,1'b1,1'b0,4'd0, 1'b0,1'b1,1'b0,1'b1},  // R8 released
        '{1'b1,1'b1,1'b0,4'd6, 1'b0,1'b1,1'b0,1'b1},  // R10 store and miss together
        '{1'b0,1'b0,1'b1,4'd0, 1'b0,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,4'd0, 1'b0,1'b0,1'b1,1'b0},  // R6 stalled by memory
        '{1'b0,1'b0,1'b0,4'd0, 1'b0,1'b0,1'b1,1'b0},
        '{1'b0,1'b0,1'b1,4'd0, 1'b0,1'b0,1'b1,1'b0},
        '{1'b0,1'b0,1'b0,4'd0, 1'b0,1'b0,1'b0,1'b1}   // R9 empty again
    };

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1 during reset
        repeat (2) @(negedge clk);
        #1;
        chk(32'(buf_empty), 1, "R1 buf_empty in reset");
        chk(32'(mem_wr_valid), 0, "R1 mem_wr_valid in reset");
        chk(32'(cpu_hold), 0, "R1 cpu_hold in reset");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = TBL[i];
            cycle(v.wr, v.rd, v.rdy, int'(v.k));
            chk(32'(cpu_hold), 32'(v.hold), $sformatf("R2/R3/R4/R8/R10 cpu_hold row %0d", i));
            chk(32'(fetch_go), 32'(v.fetch), $sformatf("R8/R10 fetch_go row %0d", i));
            chk(32'(mem_wr_valid), 32'(v.mv), $sformatf("R7 mem_wr_valid row %0d", i));
            chk(32'(buf_empty), 32'(v.emp), $sformatf("R9 buf_empty row %0d", i));
        end
        // R3: the store held on a full buffer reached memory once, R5 all drained
        chk(32'(posted), 6, "R3 stores accepted");
        chk(32'(taken), 6, "R5 memory writes completed");

        // R1: stores posted before a reset are lost, the block restarts clean
        cycle(1'b1, 1'b0, 1'b0, 8);
        cycle(1'b1, 1'b0, 1'b0, 9);
        @(negedge clk);
        cpu_wr_req   = 1'b0;
        mem_wr_ready = 1'b0;
        rst_n        = 1'b0;
        #1;
        chk(32'(buf_empty), 1, "R1 buf_empty after mid-run reset");
        chk(32'(mem_wr_valid), 0, "R1 mem_wr_valid after mid-run reset");
        rp = 0;
        wp = 0;
        taken = 0;
        @(negedge clk);
        rst_n = 1'b1;
        cycle(1'b0, 1'b0, 1'b1, 0);
        chk(32'(mem_wr_valid), 0, "R1 no stale write after reset");
        chk(32'(buf_empty), 1, "R1 empty after reset release");
        cycle(1'b1, 1'b0, 1'b1, 10);
        for (int j = 0; j < 4; j++) cycle(1'b0, 1'b0, 1'b1, 0);
        chk(32'(taken), 1, "R5 single write after reset");
        chk(32'(buf_empty), 1, "R9 empty after final drain");
        finish_run();
    end

endmodule